// File: doc/BRIEF.md
# Bit Clock Recovery Unit

This block rebuilds a bit clock from a received serial data stream that has no clock of its own. A phase counter steps once per time-base tick and wraps after a programmed number of ticks, so the nominal bit period is the rate setting times the tick interval. Every time the synchronized data changes level, the counter phase is moved toward the point where that transition ought to fall, by at most a programmed number of ticks. Once locked, the rising edge of the recovered clock sits in the middle of each bit.

The correction is a bounded nudge, not a restart of the counter at the edge. A late or early transition caused by noise therefore moves the clock by a small amount only. A correction can never make the counter cross a bit boundary, so the clock never gains or loses a cycle. The step size sets how much transmitter-to-receiver rate error can be absorbed. A large step pulls in quickly but jitters. A small step is steady but may fall behind the data.

The clock starts running as soon as the enable is set and does not wait for any message indication. A second enable can hold the clock idle while the received signal strength is reported as too low. On each rising edge of the recovered clock, the current data level is captured onto the data output.

Top module: `bitclk_recover`

## Requirements
- R1: While reset is asserted, the clock output and the data output are both 0.
- R2: With no data transitions, the recovered clock has a period of exactly rate_cfg ticks. A rate_cfg value of 0 or 1 is treated as 2.
- R3: After rec_en is set, the clock runs even if the data input never changes.
- R4: While rec_en is 0, data_clk stays 0. After rec_en is set, the first rising edge comes about half a period later, because the counter restarts from count 0.
- R5: While rssi_gate_en is 1 and rssi_ok is 0, data_clk stays 0. When rssi_gate_en is 0, rssi_ok has no effect.
- R6: A data transition seen while the count is in the upper half of the period advances the phase by tol_cfg ticks, so the current period is shortened by tol_cfg ticks.
- R7: A data transition seen while the count is in the lower half of the period retards the phase by tol_cfg ticks, so the current period is lengthened by tol_cfg ticks.
- R8: A correction is clamped so that the count stays between 0 and rate-1 and never crosses into the next or the previous bit. The clock level therefore never changes because of a correction.
- R9: data_clk is high while the count is at or above floor(rate/2), so its high time is rate - floor(rate/2) ticks.
- R10: data_bit takes the synchronized data level only on a rising edge of data_clk, and holds it at all other times.
- R11: After a preamble of alternating bits, every data bit produces exactly one rising edge of data_clk, and data_bit matches the transmitted bit. This holds with a transmit period up to 1 tick off nominal and with transitions jittered by a few cycles.
- R12: With tol_cfg = 0, data transitions do not change the clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time-base step strobe, one clk cycle wide |
| rx_data | input | 1 | Raw received data, asynchronous to clk |
| rec_en | input | 1 | Enables clock recovery |
| rssi_ok | input | 1 | Received signal strength is above threshold |
| rssi_gate_en | input | 1 | When 1, data_clk is held idle while rssi_ok is 0 |
| rate_cfg | input | RATE_W | Bit period in ticks |
| tol_cfg | input | TOL_W | Phase correction step in ticks |
| data_clk | output | 1 | Recovered bit clock |
| data_bit | output | 1 | Data level captured on the rising edge of data_clk |

## Verification
The assertions check, on every cycle, that:
- the count stays inside the programmed period;
- the clock is low while disabled or gated;
- the clock level changes only after a tick, never as a direct result of a correction;
- data_bit moves only on a rising edge of data_clk.

Only the bench scenarios can show:
- the exact size of an advance or a retard, and its clamping;
- the period and the high time for even, odd and undersized rates;
- that a mismatched, jittered stream is recovered bit for bit, with one clock per bit, once the preamble has pulled the phase in.

// File: rtl/bcr_pkg.sv
// Package shared by the bit clock recovery blocks.
// Holds the default widths and the encoding of the correction direction.
package bcr_pkg;
    localparam int DEF_RATE_W = 8;
    localparam int DEF_TOL_W  = 8;

    typedef enum logic [1:0] {
        CORR_NONE    = 2'd0,
        CORR_RETARD  = 2'd1,
        CORR_ADVANCE = 2'd2
    } corr_dir_e;
endpackage

// File: rtl/bcr_sync_edge.sv
// Brings the asynchronous rx input into the clk domain through STAGES flops.
// A level change is flagged by comparing the last stage with one extra
// history flop.
// Assumes: STAGES >= 2, and rx holds each level for many clk cycles.
module bcr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_sync,
    output logic rx_edge
);
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= rx_in;
    end

    // Remaining stages of the synchronizer chain.
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // History flop used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= chain_q[STAGES-1];
    end

    assign rx_sync = chain_q[STAGES-1];
    assign rx_edge = chain_q[STAGES-1] ^ hist_q;
endmodule

// File: rtl/bcr_phase_ctr.sv
// Bit phase counter. It counts 0 .. rate-1 on ticks.
// On a data edge, it pulls the count toward 0 by at most tol ticks:
//   - an edge in the lower half retards the count, but not below 0;
//   - an edge in the upper half advances it, but not past rate-1.
// A tick in the same cycle is applied after the correction.
// Assumes: rate >= 2 (the top clamps it), and half = rate/2.
module bcr_phase_ctr
    import bcr_pkg::*;
#(
    parameter int RATE_W = DEF_RATE_W,
    parameter int TOL_W  = DEF_TOL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              edge_det,
    input  logic [RATE_W-1:0] rate,
    input  logic [RATE_W-1:0] half,
    input  logic [TOL_W-1:0]  tol,
    output logic [RATE_W-1:0] cnt,
    output logic [RATE_W-1:0] cnt_next
);
    localparam int W = ((RATE_W > TOL_W) ? RATE_W : TOL_W) + 1;

    logic [RATE_W-1:0] cnt_q;
    logic [W-1:0]      c_w, t_w, e_w, h_w, corr_w, step_w;
    corr_dir_e         dir;

    // Widen the operands so the sums and compares cannot overflow.
    always_comb begin
        c_w = {{(W-RATE_W){1'b0}}, cnt_q};
        t_w = {{(W-TOL_W){1'b0}}, tol};
        e_w = {{(W-RATE_W){1'b0}}, rate};
        h_w = {{(W-RATE_W){1'b0}}, half};
    end

    // Pick the direction of the correction from the current count.
    always_comb begin
        if (!edge_det)      dir = CORR_NONE;
        else if (c_w < h_w) dir = CORR_RETARD;
        else                dir = CORR_ADVANCE;
    end

    // Apply the clamped correction, then the tick step.
    always_comb begin
        case (dir)
            CORR_RETARD:  corr_w = (c_w > t_w) ? (c_w - t_w) : '0;
            CORR_ADVANCE: corr_w = ((c_w + t_w) >= (e_w - 1'b1)) ? (e_w - 1'b1) : (c_w + t_w);
            default:      corr_w = (c_w >= e_w) ? (e_w - 1'b1) : c_w;
        endcase
        if (tick) step_w = (corr_w >= (e_w - 1'b1)) ? '0 : (corr_w + 1'b1);
        else      step_w = corr_w;
        cnt_next = active ? step_w[RATE_W-1:0] : '0;
    end

    // Phase count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bcr_clk_out.sv
// Drives the registered recovered clock, high for the upper half of the count.
// Captures the synchronized data level on each rising clock edge.
// Assumes: cnt_next is the value the phase counter loads this cycle.
module bcr_clk_out #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [RATE_W-1:0] cnt_next,
    input  logic [RATE_W-1:0] half,
    input  logic              rx_sync,
    output logic              data_clk,
    output logic              data_bit
);
    logic clk_nx, clk_q, bit_q;

    assign clk_nx = active && (cnt_next >= half);

    // Clock level register and data capture on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            bit_q <= 1'b0;
        end else begin
            clk_q <= clk_nx;
            if (clk_nx && !clk_q) bit_q <= rx_sync;
        end
    end

    assign data_clk = clk_q;
    assign data_bit = bit_q;
endmodule

// File: rtl/bitclk_recover.sv
// Bit clock recovery top level. It wires the synchronizer, the phase counter
// and the clock output stage together.
// It also derives the active condition (enable and signal gating) and the
// clamped rate.
// Assumes: tick is a single-cycle strobe, and the settings change only
// rarely.
module bitclk_recover
    import bcr_pkg::*;
#(
    parameter int RATE_W = DEF_RATE_W,
    parameter int TOL_W  = DEF_TOL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_data,
    input  logic              rec_en,
    input  logic              rssi_ok,
    input  logic              rssi_gate_en,
    input  logic [RATE_W-1:0] rate_cfg,
    input  logic [TOL_W-1:0]  tol_cfg,
    output logic              data_clk,
    output logic              data_bit
);
    localparam logic [RATE_W-1:0] MIN_RATE = RATE_W'(2);

    logic              rx_sync, rx_edge, active;
    logic [RATE_W-1:0] eff_rate, half, cnt_q, cnt_next;

    // Active when enabled and not held by the signal-strength gate.
    assign active   = rec_en && !(rssi_gate_en && !rssi_ok);
    assign eff_rate = (rate_cfg < MIN_RATE) ? MIN_RATE : rate_cfg;
    assign half     = eff_rate >> 1;

    bcr_sync_edge #(.STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_in   (rx_data),
        .rx_sync (rx_sync),
        .rx_edge (rx_edge)
    );

    bcr_phase_ctr #(.RATE_W(RATE_W), .TOL_W(TOL_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (tick),
        .edge_det (rx_edge),
        .rate     (eff_rate),
        .half     (half),
        .tol      (tol_cfg),
        .cnt      (cnt_q),
        .cnt_next (cnt_next)
    );

    bcr_clk_out #(.RATE_W(RATE_W)) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .cnt_next (cnt_next),
        .half     (half),
        .rx_sync  (rx_sync),
        .data_clk (data_clk),
        .data_bit (data_bit)
    );
endmodule

// File: rtl/bcr_checker.sv
// Property checker for bitclk_recover, attached with the bind below.
module bcr_checker #(
    parameter int RATE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              rec_en,
    input logic              rssi_ok,
    input logic              rssi_gate_en,
    input logic [RATE_W-1:0] rate_cfg,
    input logic              data_clk,
    input logic              data_bit,
    input logic [RATE_W-1:0] cnt,
    input logic [RATE_W-1:0] eff_rate
);
    logic run;
    assign run = rec_en && !(rssi_gate_en && !rssi_ok);

    // R8
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rate_cfg) |-> (cnt < eff_rate));

    // R4
    off_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> !data_clk);

    // R5
    gated_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rssi_gate_en && !rssi_ok) |=> !data_clk);

    // R8
    level_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_clk != $past(data_clk)) && $past(run) && ($past(rate_cfg) == $past(rate_cfg, 2)))
            |-> $past(tick));

    // R10
    bit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(data_clk) |-> $stable(data_bit));
endmodule

bind bitclk_recover bcr_checker #(.RATE_W(RATE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .rec_en       (rec_en),
    .rssi_ok      (rssi_ok),
    .rssi_gate_en (rssi_gate_en),
    .rate_cfg     (rate_cfg),
    .data_clk     (data_clk),
    .data_bit     (data_bit),
    .cnt          (cnt_q),
    .eff_rate     (eff_rate)
);

// File: tb/bitclk_recover_tb_top.sv
`timescale 1ns/1ps
module bitclk_recover_tb_top;
    localparam int RW = 8;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n, tick, rx_data, rec_en, rssi_ok, rssi_gate_en;
    logic [RW-1:0] rate_cfg;
    logic [TW-1:0] tol_cfg;
    logic          data_clk, data_bit;

    always #2 clk = ~clk;

    bitclk_recover #(.RATE_W(RW), .TOL_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_data(rx_data),
        .rec_en(rec_en), .rssi_ok(rssi_ok), .rssi_gate_en(rssi_gate_en),
        .rate_cfg(rate_cfg), .tol_cfg(tol_cfg),
        .data_clk(data_clk), .data_bit(data_bit)
    );

    int     errs = 0, checks = 0;
    longint cyc = 0, rise_cyc = 0, fall_cyc = 0;
    int     rise_cnt = 0, fall_cnt = 0;
    logic   dprev = 1'b0, sb_on = 1'b0, tick_run = 1'b0, done = 1'b0;
    bit     exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    // Tick every second clock cycle, driven away from the active edge.
    always @(negedge clk) tick <= tick_run ? ~tick : 1'b0;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(string req, longint act, longint lo, longint hi);
        checks++;
        if (act < lo || act > hi) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // Monitor: edge bookkeeping and scoreboard compare on each rising edge.
    always @(negedge clk) begin
        if (data_clk && !dprev) begin
            rise_cnt++;
            rise_cyc = cyc;
            if (sb_on && exp_q.size() > 0) begin
                bit e;
                e = exp_q.pop_front();
                checks++;
                if (data_bit !== e) begin
                    errs++;
                    $display("FAIL R10 R11 actual=%0d expected=%0d", data_bit, e);
                end
            end
        end
        if (!data_clk && dprev) begin
            fall_cnt++;
            fall_cyc = cyc;
        end
        dprev = data_clk;
    end

    task automatic wait_rise(output longint t);
        int c = rise_cnt;
        do @(posedge clk); while (rise_cnt == c);
        t = rise_cyc;
    endtask

    task automatic wait_fall(output longint t);
        int c = fall_cnt;
        do @(posedge clk); while (fall_cnt == c);
        t = fall_cyc;
    endtask

    // Driver: sends a preamble and a payload. Each payload bit is pushed
    // to the scoreboard a quarter period after its transition.
    task automatic send_stream(int n_pre, int n_pay, int per, int jit);
        logic [31:0] pat = 32'hC5A3_9E17;
        for (int i = 0; i < n_pre + n_pay; i++) begin
            bit b;
            int d;
            b = (i < n_pre) ? bit'(i % 2) : pat[(i - n_pre) % 32];
            d = per + ((i % 3 == 1) ? jit : (i % 3 == 2) ? -jit : 0);
            @(negedge clk);
            rx_data = b;
            for (int k = 1; k < d; k++) begin
                if (k == 10 && i >= n_pre) exp_q.push_back(b);
                @(negedge clk);
            end
        end
        repeat (80) @(negedge clk);
        chk("R11 leftover bits", exp_q.size(), 0);
    endtask

    // Toggles the data line a given number of cycles after a rising edge.
    // Returns the interval to the next rising edge.
    task automatic edge_after(int delay, output longint iv);
        longint t0, t1;
        wait_rise(t0);
        repeat (delay) @(negedge clk);
        rx_data = ~rx_data;
        wait_rise(t1);
        iv = t1 - t0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        longint t0, t1, iv;
        int     c0;
        rst_n = 0; rec_en = 0; rssi_ok = 1; rssi_gate_en = 0;
        rx_data = 0; rate_cfg = 8'd20; tol_cfg = 8'd3;
        tick_run = 1;
        repeat (6) @(negedge clk);
        chk("R1 data_clk", data_clk, 0);
        chk("R1 data_bit", data_bit, 0);
        rst_n = 1;

        // R4: disabled clock stays low
        c0 = rise_cnt;
        repeat (100) @(negedge clk);
        chk("R4 no edges while off", rise_cnt - c0, 0);
        chk("R4 level while off", data_clk, 0);

        // R3 R4: runs without data, first edge about half a period later
        rec_en = 1;
        t0 = cyc;
        wait_rise(t1);
        chk_rng("R4 first edge delay", t1 - t0, 18, 24);
        chk("R3 runs without data", rx_data, 0);

        // R2 R9: period and high time at rate 20
        wait_rise(t0); wait_rise(t1);
        chk("R2 period rate 20", t1 - t0, 40);
        wait_fall(iv);
        chk("R9 high time rate 20", iv - t1, 20);

        // Odd rate 7
        @(negedge clk); rate_cfg = 8'd7;
        wait_rise(t0); wait_rise(t0); wait_rise(t1);
        chk("R2 period rate 7", t1 - t0, 14);
        wait_fall(iv);
        chk("R9 high time rate 7", iv - t1, 8);

        // Undersized rate 1 is treated as 2
        @(negedge clk); rate_cfg = 8'd1;
        wait_rise(t0); wait_rise(t0); wait_rise(t1);
        chk("R2 period rate 1 clamped", t1 - t0, 4);

        @(negedge clk); rate_cfg = 8'd20;
        wait_rise(t0); wait_rise(t0);

        // R6 and R7: corrections of tol ticks
        edge_after(3, iv);
        chk("R6 advance shortens period", iv, 34);
        edge_after(25, iv);
        chk("R7 retard lengthens period", iv, 46);

        // R12: zero step leaves the period unchanged
        @(negedge clk); tol_cfg = 8'd0;
        edge_after(3, iv);
        chk("R12 upper-half edge no shift", iv, 40);
        edge_after(25, iv);
        chk("R12 lower-half edge no shift", iv, 40);

        // R8: large step is clamped at the bit boundary
        @(negedge clk); tol_cfg = 8'd15;
        edge_after(25, iv);
        chk_rng("R8 retard clamped", iv, 41, 55);
        edge_after(3, iv);
        chk_rng("R8 advance clamped", iv, 20, 39);

        // R5: signal-strength gating
        @(negedge clk); tol_cfg = 8'd3; rssi_gate_en = 1; rssi_ok = 0;
        repeat (3) @(negedge clk);
        c0 = rise_cnt;
        repeat (100) @(negedge clk);
        chk("R5 gated no edges", rise_cnt - c0, 0);
        chk("R5 gated level", data_clk, 0);
        rssi_ok = 1; t0 = cyc;
        wait_rise(t1);
        chk_rng("R5 resumes", t1 - t0, 18, 24);
        @(negedge clk); rssi_gate_en = 0; rssi_ok = 0;
        wait_rise(t0); wait_rise(t1);
        chk("R5 ignored when gate off", t1 - t0, 40);
        rssi_ok = 1;

        // R10 R11: scoreboarded streams
        sb_on = 1;
        send_stream(8, 32, 40, 0);
        send_stream(8, 32, 41, 2);
        send_stream(8, 32, 39, 3);
        sb_on = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule